// File: doc/BRIEF.md
# Transmit Jabber Watchdog Timer

This block sits beside the transmit path of an Ethernet MAC. It counts the bytes of each outgoing frame and stops the transmitter when a frame runs past a length limit. A byte-valid strobe qualifies every byte. A start-of-frame marker and an end-of-frame marker ride on the first and last byte of a frame.

There are two limits: a standard one and a larger one for jumbo frames. The limit for a frame is chosen by the jumbo-enable input, which is sampled on the start-of-frame byte. When the first byte beyond the limit arrives, the block does three things:
- it raises an abort request that holds the transmit process stopped;
- it emits a single-cycle jabber event for the status register;
- it sets the jabber bit of the descriptor status word written back for that frame.

The transmit engine leaves the stopped state by beginning a new frame.

Top module: `tx_jabber_guard`

## Requirements
- R1: A frame of exactly the selected limit in bytes, closed by end-of-frame, completes with `abort_req`, `jab_pulse` and `desc_status` all staying zero.
- R2: With jumbo mode off at start-of-frame, byte number STD_LIMIT+1 of a frame is over the limit. The clock edge that takes that byte sets `abort_req` and `jab_pulse`, and they are visible in the following cycle.
- R3: With jumbo mode on at start-of-frame, the limit is JUMBO_LIMIT. A frame of JUMBO_LIMIT bytes completes normally, and byte JUMBO_LIMIT+1 causes expiry.
- R4: After expiry, `abort_req` stays high (the stopped state) through any further bytes or end-of-frame. It drops only on the edge that takes a new start-of-frame byte.
- R5: `jab_pulse` is high for exactly one cycle per expiry, and there is at most one expiry per frame. The count saturates once the frame is aborted.
- R6: `desc_status` is 32 bits. Bit 14 is the jabber flag and all other bits are zero. The flag is set together with `jab_pulse`, holds after the frame, and is cleared by the next start-of-frame byte.
- R7: `jumbo_en` matters only on the start-of-frame byte. Changing it in the middle of a frame does not change that frame's limit.
- R8: While reset is asserted and right after it, `abort_req`, `jab_pulse` and `desc_status` are zero.
- R9: A start-of-frame byte always restarts the count at one, even inside a frame that has no end-of-frame yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A frame byte is present this cycle |
| sof | input | 1 | The present byte is the first of a frame |
| eof | input | 1 | The present byte is the last of a frame |
| jumbo_en | input | 1 | Selects the jumbo limit; sampled with the start-of-frame byte |
| abort_req | output | 1 | Transmit process stopped by jabber expiry |
| jab_pulse | output | 1 | One-cycle jabber event for the status register |
| desc_status | output | 32 | Descriptor status contribution; bit 14 is the jabber flag |

## Verification
The bench builds the block with STD_LIMIT=16 and JUMBO_LIMIT=40. With these values, frames at each limit, one byte over each limit, and frames that cross the standard limit under a jumbo selection all take only tens of cycles. The same counter, compare and selection logic is used as with the full-size defaults. A behavioural model predicts every output on every clock, and directed frames address the exact-limit boundary, mid-frame jumbo changes, bytes sent after an abort, and a restart in the middle of a frame.

// File: rtl/tx_jabber_pkg.sv
package tx_jabber_pkg;
  typedef enum logic [1:0] {
    TJ_IDLE    = 2'd0,
    TJ_ACTIVE  = 2'd1,
    TJ_STOPPED = 2'd2
  } tj_state_e;

  localparam int unsigned DESC_W       = 32;
  localparam int unsigned DESC_JAB_BIT = 14;
endpackage

// File: rtl/jabber_limit_select.sv
module jabber_limit_select #(
  parameter int unsigned STD_LIMIT   = 2048,
  parameter int unsigned JUMBO_LIMIT = 10240,
  parameter int unsigned CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             jumbo_en,
  output logic [CNT_W-1:0] limit
);
  localparam logic [CNT_W-1:0] STD_L   = CNT_W'(STD_LIMIT);
  localparam logic [CNT_W-1:0] JUMBO_L = CNT_W'(JUMBO_LIMIT);

  logic [CNT_W-1:0] lim_q, lim_d, live_lim;

  always_comb begin
    live_lim = jumbo_en ? JUMBO_L : STD_L;
    lim_d    = lim_q;
    if (load_en) lim_d = live_lim;
    limit    = load_en ? live_lim : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lim_q <= STD_L;
    else if (load_en) lim_q <= lim_d;
  end

  // Frame limit only changes when a frame starts.
  p_limit_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(lim_q));
endmodule

// File: rtl/jabber_byte_counter.sv
module jabber_byte_counter #(
  parameter int unsigned JUMBO_LIMIT = 10240,
  parameter int unsigned CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (start)     cnt_nxt = CNT_W'(1);
    else if (take) cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start || take) cnt_q <= cnt_nxt;
  end

  // Count never runs past one beyond the largest limit (saturation).
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(JUMBO_LIMIT + 1));
endmodule

// File: rtl/jabber_abort_ctrl.sv
module jabber_abort_ctrl
  import tx_jabber_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] limit,
  output logic             start,
  output logic             take,
  output logic             abort_req,
  output logic             jab_pulse,
  output logic             jab_flag
);
  tj_state_e state_q, state_d;
  logic      pulse_q, pulse_d;
  logic      flag_q, flag_d;
  logic      over;

  always_comb begin
    start = byte_vld && sof;
    take  = byte_vld && !sof && (state_q == TJ_ACTIVE);
    over  = (start || take) && (cnt_nxt > limit);
  end

  always_comb begin
    state_d = state_q;
    if (over)               state_d = TJ_STOPPED;
    else if (start)         state_d = eof ? TJ_IDLE : TJ_ACTIVE;
    else if (take && eof)   state_d = TJ_IDLE;
    pulse_d = over;
    flag_d  = over || (flag_q && !start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TJ_IDLE;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign abort_req = (state_q == TJ_STOPPED);
  assign jab_pulse = pulse_q;
  assign jab_flag  = flag_q;

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jab_pulse |=> !jab_pulse);
  p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> jab_pulse);
  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !(byte_vld && sof)) |=> abort_req);
  p_flag_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jab_pulse |-> jab_flag);
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard
  import tx_jabber_pkg::*;
#(
  parameter int unsigned STD_LIMIT   = 2048,
  parameter int unsigned JUMBO_LIMIT = 10240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              sof,
  input  logic              eof,
  input  logic              jumbo_en,
  output logic              abort_req,
  output logic              jab_pulse,
  output logic [DESC_W-1:0] desc_status
);
  localparam int unsigned CNT_W = $clog2(JUMBO_LIMIT + 2);

  logic             start, take, jab_flag;
  logic [CNT_W-1:0] cnt_nxt, limit;

  jabber_limit_select #(
    .STD_LIMIT(STD_LIMIT), .JUMBO_LIMIT(JUMBO_LIMIT), .CNT_W(CNT_W)
  ) u_limit (
    .clk(clk), .rst_n(rst_n), .load_en(start), .jumbo_en(jumbo_en),
    .limit(limit)
  );

  jabber_byte_counter #(
    .JUMBO_LIMIT(JUMBO_LIMIT), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take), .cnt_nxt(cnt_nxt)
  );

  jabber_abort_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
    .cnt_nxt(cnt_nxt), .limit(limit), .start(start), .take(take),
    .abort_req(abort_req), .jab_pulse(jab_pulse), .jab_flag(jab_flag)
  );

  always_comb begin
    desc_status               = '0;
    desc_status[DESC_JAB_BIT] = jab_flag;
  end

  p_desc_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jab_pulse |-> desc_status[DESC_JAB_BIT]);
endmodule

// File: tb/test_tx_jabber_guard.sv
module test_tx_jabber_guard;
  localparam int unsigned STD_L   = 16;
  localparam int unsigned JUMBO_L = 40;
  localparam time         CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n, byte_vld, sof, eof, jumbo_en;
  logic        abort_req, jab_pulse;
  logic [31:0] desc_status;

  int checks = 0, failures = 0, cycles = 0, pulse_total = 0;

  // behavioural reference state
  int m_lim = 0, m_n = 0;
  bit m_act = 0, m_stop = 0, m_pulse = 0, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_jabber_guard #(.STD_LIMIT(STD_L), .JUMBO_LIMIT(JUMBO_L)) i_tx_jabber_guard (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
    .jumbo_en(jumbo_en), .abort_req(abort_req), .jab_pulse(jab_pulse),
    .desc_status(desc_status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_stop = 0; m_pulse = 0; m_flag = 0; m_n = 0;
    end else begin
      m_pulse = 0;
      if (byte_vld && sof) begin
        m_lim = jumbo_en ? JUMBO_L : STD_L;
        m_n = 1; m_flag = 0; m_stop = 0; m_act = 1;
      end else if (byte_vld && m_act) begin
        m_n++;
      end else begin
        m_n = -1;
      end
      if (m_n > m_lim) begin
        m_stop = 1; m_pulse = 1; m_flag = 1; m_act = 0;
      end else if (m_n > 0 && eof) begin
        m_act = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (jab_pulse) pulse_total++;
    if (rst_n) begin
      check(abort_req == m_stop, "R4 abort_req vs model", abort_req, m_stop);
      check(jab_pulse == m_pulse, "R5 jab_pulse vs model", jab_pulse, m_pulse);
      check(desc_status == (m_flag ? 32'h4000 : 32'h0), "R6 desc_status vs model",
            desc_status, m_flag ? 32'h4000 : 0);
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 0; sof = 0; eof = 0;
    end
  endtask

  task automatic frame(input int len, input bit j_sof, input bit j_mid, input bit close);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byte_vld = 1;
      sof      = (i == 0);
      eof      = close && (i == len - 1);
      jumbo_en = (i == 0) ? j_sof : j_mid;
    end
    idle(2);
  endtask

  initial begin
    int p0;
    rst_n = 0; byte_vld = 0; sof = 0; eof = 0; jumbo_en = 0;
    repeat (3) @(negedge clk);
    check(abort_req == 0 && jab_pulse == 0 && desc_status == 0, "R8 reset outputs",
          {abort_req, jab_pulse}, 0);
    rst_n = 1;
    idle(2);
    check(abort_req == 0 && desc_status == 0, "R8 after release", abort_req, 0);

    p0 = pulse_total;
    frame(STD_L, 0, 0, 1);
    check(abort_req == 0 && pulse_total == p0, "R1 exact standard limit", abort_req, 0);

    p0 = pulse_total;
    frame(STD_L + 1, 0, 0, 0);
    check(abort_req == 1, "R2 one byte over standard", abort_req, 1);
    check(pulse_total - p0 == 1, "R5 single pulse", pulse_total - p0, 1);
    check(desc_status == 32'h4000, "R6 jabber bit 14 set", desc_status, 32'h4000);

    // trailing bytes and eof while stopped
    p0 = pulse_total;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_vld = 1; sof = 0; eof = (i == 3);
    end
    idle(2);
    check(abort_req == 1 && pulse_total == p0, "R4 stopped holds", abort_req, 1);
    check(desc_status == 32'h4000, "R6 flag held", desc_status, 32'h4000);

    p0 = pulse_total;
    frame(JUMBO_L, 1, 1, 1);
    check(abort_req == 0 && pulse_total == p0, "R3 exact jumbo limit", abort_req, 0);
    check(desc_status == 0, "R6 flag cleared at sof", desc_status, 0);

    p0 = pulse_total;
    frame(JUMBO_L + 1, 1, 1, 1);
    check(abort_req == 1 && pulse_total - p0 == 1, "R3 one byte over jumbo", abort_req, 1);

    p0 = pulse_total;
    frame(STD_L + 5, 1, 0, 1);
    check(abort_req == 0 && pulse_total == p0, "R7 jumbo dropped mid-frame", abort_req, 0);

    p0 = pulse_total;
    frame(STD_L + 1, 0, 1, 1);
    check(abort_req == 1 && pulse_total - p0 == 1, "R7 jumbo raised mid-frame", abort_req, 1);

    p0 = pulse_total;
    frame(STD_L - 2, 0, 0, 0);
    frame(STD_L, 0, 0, 1);
    check(abort_req == 0 && pulse_total == p0, "R9 sof restarts count", abort_req, 0);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule